// File: doc/BRIEF.md
# Per-CPU Interrupt Presenter

This block keeps the interrupt state of a single processor. It holds the processor's current priority, one pending source number with the priority that source arrived at, and a software-written inter-processor interrupt priority. Smaller numbers are more favoured. A source layer offers interrupts to the block. The block either keeps an offered interrupt or hands it straight back on a reject strobe, so at most one interrupt is ever pending. The inter-processor interrupt takes part in this contest as a virtual source with a reserved number.

The processor drives five register operations: set priority, set IPI priority, accept, end-of-interrupt and poll. These operations move the interrupt line, displace or reinstate the pending interrupt, and ask the source layer to resend earlier rejected interrupts when the processor's priority becomes less restrictive. Accept and poll return the packed state word one cycle later. All outputs are registered.

Top module: `irq_presenter`

## Requirements
- R1: After reset the priority is 0x00, the IPI priority is 0xFF, nothing is pending (source number 0), the pending priority is 0xFF and the interrupt line is low.
- R2: An offered interrupt is rejected when its priority is greater than or equal to the current priority, or when an interrupt is pending whose priority is less than or equal to the offered one. The reject goes out on lane 1 carrying the offered number, and the state does not change.
- R3: An offered interrupt that is not rejected displaces any pending interrupt, which is rejected on lane 1. Its number and priority are latched, and the interrupt line goes high.
- R4: Set IPI priority stores the value. If the value is less than the current priority, an IPI check runs. The check does nothing when the pending priority is less than or equal to the IPI priority. Otherwise it rejects any pending source on lane 0, makes source number 2 pending at the IPI priority and raises the line.
- R5: Set priority with a value below the old priority, while the pending priority is greater than or equal to the new value, clears the pending number, sets the pending priority to 0xFF, lowers the line and rejects the old source on lane 0. Whenever the pending number is 0, the pending priority is 0xFF.
- R6: Set priority with a value greater than or equal to the old priority, while nothing is pending, performs a resend. A resend pulses the resend request for one cycle and runs the IPI check when the IPI priority is below the new priority.
- R7: Accept returns the state word as it was before the operation. It then lowers the line, copies the pending priority into the current priority and clears the pending number.
- R8: End-of-interrupt loads the current priority from bits [31:24] of the operand and pulses the EOI strobe with bits [23:0] of the operand. If nothing is pending, it performs a resend.
- R9: Poll returns the state word and the IPI priority one cycle later, with rsp_valid high, and changes no state.
- R10: When an operation and an offered interrupt arrive in the same cycle, the operation is applied first. The offered interrupt is then judged against the state the operation leaves behind. Rejects caused by the operation use lane 0 and rejects caused by the offer use lane 1, so both can fire in the same cycle.
- R11: A displaced inter-processor interrupt (number 2) never appears on a reject lane. It stays recorded in the IPI priority.
- R12: The state word holds the current priority in bits [31:24] and the pending number in bits [23:0]. op_code encodings: 1 set priority (operand [7:0]), 2 set IPI priority (operand [7:0]), 3 accept, 4 end-of-interrupt, 5 poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source layer offers an interrupt this cycle |
| src_num | input | 24 | Offered source number (0 and 2 are reserved) |
| src_prio | input | 8 | Offered priority |
| op_valid | input | 1 | Processor register operation this cycle |
| op_code | input | 3 | Operation code (see R12) |
| op_data | input | 32 | Operation operand |
| irq_out | output | 1 | Level interrupt line to the processor |
| rej_valid | output | 2 | Reject strobes: bit 0 operation lane, bit 1 offer lane |
| rej_num | output | 48 | Rejected numbers: [23:0] lane 0, [47:24] lane 1 |
| eoi_valid | output | 1 | End-of-interrupt strobe to the source layer |
| eoi_num | output | 24 | Source number carried by the EOI strobe |
| resend_req | output | 1 | Request to resend rejected interrupts |
| rsp_valid | output | 1 | Accept or poll response valid |
| rsp_xirr | output | 32 | Returned state word |
| rsp_mfrr | output | 8 | Returned IPI priority |

## Verification
A processor operation and an interrupt offer from the source layer can land in the same cycle. When they do, they can together displace and reject two different sources. The bench provokes this by pairing set-priority and set-IPI-priority writes with offers of chosen priority in one cycle. It checks which lanes fire, which numbers each lane carries, and the state word a following poll returns. The cases cover an offer that beats a freshly raised IPI without any reject, an offer that wins after the operation has ejected the old source, and an offer that loses to the new priority while the operation also ejects the pending source.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_CPPR   = 3'd1,
    OP_MFRR   = 3'd2,
    OP_ACCEPT = 3'd3,
    OP_EOI    = 3'd4,
    OP_POLL   = 3'd5
  } prs_op_e;

  localparam int unsigned REJ_LANES = 2;
  localparam int unsigned LANE_OP   = 0;
  localparam int unsigned LANE_SRC  = 1;
endpackage

// File: rtl/prs_ipi_check.sv
module prs_ipi_check #(
  parameter int unsigned NUM_W   = 24,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IPI_NUM = 2
) (
  input  logic [NUM_W-1:0]  xisr_i,
  input  logic [PRIO_W-1:0] pprio_i,
  input  logic [PRIO_W-1:0] mfrr_i,
  output logic [NUM_W-1:0]  xisr_o,
  output logic [PRIO_W-1:0] pprio_o,
  output logic              rej_o,
  output logic [NUM_W-1:0]  rej_num_o
);
  localparam logic [NUM_W-1:0] IPI = NUM_W'(IPI_NUM);

  logic busy;
  logic keep;

  assign busy = (xisr_i != '0);
  // The pending interrupt holds its place if it is at least as favoured.
  assign keep = busy && (pprio_i <= mfrr_i);

  always_comb begin
    xisr_o    = xisr_i;
    pprio_o   = pprio_i;
    rej_o     = 1'b0;
    rej_num_o = xisr_i;
    if (!keep) begin
      xisr_o  = IPI;
      pprio_o = mfrr_i;
      rej_o   = busy && (xisr_i != IPI);
    end
  end
endmodule

// File: rtl/prs_op_unit.sv
module prs_op_unit
  import prs_pkg::*;
#(
  parameter int unsigned NUM_W   = 24,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IPI_NUM = 2,
  localparam int unsigned XIRR_W = NUM_W + PRIO_W
) (
  input  logic [PRIO_W-1:0] cppr_i,
  input  logic [NUM_W-1:0]  xisr_i,
  input  logic [PRIO_W-1:0] pprio_i,
  input  logic [PRIO_W-1:0] mfrr_i,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [XIRR_W-1:0] op_data,
  output logic [PRIO_W-1:0] cppr_o,
  output logic [NUM_W-1:0]  xisr_o,
  output logic [PRIO_W-1:0] pprio_o,
  output logic [PRIO_W-1:0] mfrr_o,
  output logic              rej_o,
  output logic [NUM_W-1:0]  rej_num_o,
  output logic              eoi_o,
  output logic [NUM_W-1:0]  eoi_num_o,
  output logic              resend_o,
  output logic              rsp_o,
  output logic [XIRR_W-1:0] rsp_xirr_o,
  output logic [PRIO_W-1:0] rsp_mfrr_o
);
  localparam logic [NUM_W-1:0] IPI = NUM_W'(IPI_NUM);

  logic [PRIO_W-1:0] cppr_m, pprio_m, mfrr_m;
  logic [NUM_W-1:0]  xisr_m;
  logic              rej_m;
  logic              resend_m;
  logic              mfrr_wr;
  logic              do_ipi;
  logic [NUM_W-1:0]  ipi_xisr;
  logic [PRIO_W-1:0] ipi_pprio;
  logic              ipi_rej;
  logic [NUM_W-1:0]  ipi_rej_num;
  logic [PRIO_W-1:0] new_prio;

  assign new_prio = op_data[PRIO_W-1:0];

  // First stage: the direct effect of the operation on the state.
  always_comb begin
    cppr_m   = cppr_i;
    xisr_m   = xisr_i;
    pprio_m  = pprio_i;
    mfrr_m   = mfrr_i;
    rej_m    = 1'b0;
    resend_m = 1'b0;
    mfrr_wr  = 1'b0;
    eoi_o    = 1'b0;
    rsp_o    = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_CPPR: begin
          cppr_m = new_prio;
          if (new_prio < cppr_i) begin
            if ((xisr_i != '0) && (pprio_i >= new_prio)) begin
              xisr_m  = '0;
              pprio_m = '1;
              rej_m   = (xisr_i != IPI);
            end
          end else if (xisr_i == '0) begin
            resend_m = 1'b1;
          end
        end
        OP_MFRR: begin
          mfrr_m  = new_prio;
          mfrr_wr = 1'b1;
        end
        OP_ACCEPT: begin
          rsp_o   = 1'b1;
          cppr_m  = pprio_i;
          xisr_m  = '0;
          pprio_m = '1;
        end
        OP_EOI: begin
          cppr_m = op_data[XIRR_W-1:NUM_W];
          eoi_o  = 1'b1;
          if (xisr_i == '0) resend_m = 1'b1;
        end
        OP_POLL: rsp_o = 1'b1;
        default: ;
      endcase
    end
  end

  // Second stage: IPI contest after a write of the IPI priority or a resend.
  assign do_ipi = (mfrr_wr || resend_m) && (mfrr_m < cppr_m);

  prs_ipi_check #(
    .NUM_W  (NUM_W),
    .PRIO_W (PRIO_W),
    .IPI_NUM(IPI_NUM)
  ) u_ipi (
    .xisr_i   (xisr_m),
    .pprio_i  (pprio_m),
    .mfrr_i   (mfrr_m),
    .xisr_o   (ipi_xisr),
    .pprio_o  (ipi_pprio),
    .rej_o    (ipi_rej),
    .rej_num_o(ipi_rej_num)
  );

  always_comb begin
    cppr_o    = cppr_m;
    mfrr_o    = mfrr_m;
    xisr_o    = do_ipi ? ipi_xisr  : xisr_m;
    pprio_o   = do_ipi ? ipi_pprio : pprio_m;
    rej_o     = rej_m || (do_ipi && ipi_rej);
    rej_num_o = (do_ipi && ipi_rej) ? ipi_rej_num : xisr_i;
  end

  assign eoi_num_o  = op_data[NUM_W-1:0];
  assign resend_o   = resend_m;
  assign rsp_xirr_o = {cppr_i, xisr_i};
  assign rsp_mfrr_o = mfrr_i;
endmodule

// File: rtl/prs_arrival.sv
module prs_arrival #(
  parameter int unsigned NUM_W   = 24,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IPI_NUM = 2
) (
  input  logic [PRIO_W-1:0] cppr_i,
  input  logic [NUM_W-1:0]  xisr_i,
  input  logic [PRIO_W-1:0] pprio_i,
  input  logic              src_valid,
  input  logic [NUM_W-1:0]  src_num,
  input  logic [PRIO_W-1:0] src_prio,
  output logic [NUM_W-1:0]  xisr_o,
  output logic [PRIO_W-1:0] pprio_o,
  output logic              rej_o,
  output logic [NUM_W-1:0]  rej_num_o
);
  localparam logic [NUM_W-1:0] IPI = NUM_W'(IPI_NUM);

  logic busy;
  logic lose;

  assign busy = (xisr_i != '0);
  assign lose = (src_prio >= cppr_i) || (busy && (pprio_i <= src_prio));

  always_comb begin
    xisr_o    = xisr_i;
    pprio_o   = pprio_i;
    rej_o     = 1'b0;
    rej_num_o = src_num;
    if (src_valid) begin
      if (lose) begin
        rej_o = 1'b1;
      end else begin
        rej_o     = busy && (xisr_i != IPI);
        rej_num_o = xisr_i;
        xisr_o    = src_num;
        pprio_o   = src_prio;
      end
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import prs_pkg::*;
#(
  parameter int unsigned NUM_W   = 24,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IPI_NUM = 2,
  localparam int unsigned XIRR_W = NUM_W + PRIO_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       src_valid,
  input  logic [NUM_W-1:0]           src_num,
  input  logic [PRIO_W-1:0]          src_prio,
  input  logic                       op_valid,
  input  logic [2:0]                 op_code,
  input  logic [XIRR_W-1:0]          op_data,
  output logic                       irq_out,
  output logic [REJ_LANES-1:0]       rej_valid,
  output logic [REJ_LANES*NUM_W-1:0] rej_num,
  output logic                       eoi_valid,
  output logic [NUM_W-1:0]           eoi_num,
  output logic                       resend_req,
  output logic                       rsp_valid,
  output logic [XIRR_W-1:0]          rsp_xirr,
  output logic [PRIO_W-1:0]          rsp_mfrr
);
  logic [PRIO_W-1:0] cppr_q, pprio_q, mfrr_q;
  logic [NUM_W-1:0]  xisr_q;

  logic [PRIO_W-1:0] cppr_op, pprio_op, mfrr_op;
  logic [NUM_W-1:0]  xisr_op;
  logic [PRIO_W-1:0] pprio_n;
  logic [NUM_W-1:0]  xisr_n;
  logic              eoi_n, resend_n, rsp_n;
  logic [NUM_W-1:0]  eoi_num_n;
  logic [XIRR_W-1:0] rsp_xirr_n;
  logic [PRIO_W-1:0] rsp_mfrr_n;
  logic [REJ_LANES-1:0] lane_v;
  logic [NUM_W-1:0]     lane_num [REJ_LANES];

  prs_op_unit #(
    .NUM_W  (NUM_W),
    .PRIO_W (PRIO_W),
    .IPI_NUM(IPI_NUM)
  ) u_op (
    .cppr_i    (cppr_q),
    .xisr_i    (xisr_q),
    .pprio_i   (pprio_q),
    .mfrr_i    (mfrr_q),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_data   (op_data),
    .cppr_o    (cppr_op),
    .xisr_o    (xisr_op),
    .pprio_o   (pprio_op),
    .mfrr_o    (mfrr_op),
    .rej_o     (lane_v[LANE_OP]),
    .rej_num_o (lane_num[LANE_OP]),
    .eoi_o     (eoi_n),
    .eoi_num_o (eoi_num_n),
    .resend_o  (resend_n),
    .rsp_o     (rsp_n),
    .rsp_xirr_o(rsp_xirr_n),
    .rsp_mfrr_o(rsp_mfrr_n)
  );

  // The offer is judged against the state the operation leaves behind.
  prs_arrival #(
    .NUM_W  (NUM_W),
    .PRIO_W (PRIO_W),
    .IPI_NUM(IPI_NUM)
  ) u_arr (
    .cppr_i   (cppr_op),
    .xisr_i   (xisr_op),
    .pprio_i  (pprio_op),
    .src_valid(src_valid),
    .src_num  (src_num),
    .src_prio (src_prio),
    .xisr_o   (xisr_n),
    .pprio_o  (pprio_n),
    .rej_o    (lane_v[LANE_SRC]),
    .rej_num_o(lane_num[LANE_SRC])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cppr_q     <= '0;
      mfrr_q     <= '1;
      xisr_q     <= '0;
      pprio_q    <= '1;
      irq_out    <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_num    <= '0;
      resend_req <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_xirr   <= '0;
      rsp_mfrr   <= '0;
    end else begin
      cppr_q     <= cppr_op;
      mfrr_q     <= mfrr_op;
      xisr_q     <= xisr_n;
      pprio_q    <= pprio_n;
      irq_out    <= (xisr_n != '0);
      eoi_valid  <= eoi_n;
      eoi_num    <= eoi_n ? eoi_num_n : '0;
      resend_req <= resend_n;
      rsp_valid  <= rsp_n;
      rsp_xirr   <= rsp_n ? rsp_xirr_n : '0;
      rsp_mfrr   <= rsp_n ? rsp_mfrr_n : '0;
    end
  end

  for (genvar g = 0; g < REJ_LANES; g++) begin : g_lane
    logic             v_q;
    logic [NUM_W-1:0] n_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        n_q <= '0;
      end else begin
        v_q <= lane_v[g];
        n_q <= lane_v[g] ? lane_num[g] : '0;
      end
    end
    assign rej_valid[g]             = v_q;
    assign rej_num[g*NUM_W +: NUM_W] = n_q;
  end

  assert property (@(posedge clk) disable iff (rst)
    (!op_valid && src_valid && (src_prio >= cppr_q))
      |=> (rej_valid[LANE_SRC] && (rej_num[LANE_SRC*NUM_W +: NUM_W] == $past(src_num))))
    else $error("assert_offer_lose_R2");

  assert property (@(posedge clk) disable iff (rst)
    (!op_valid && src_valid && (src_prio < cppr_q) && (xisr_q == '0))
      |=> (irq_out && !rej_valid[LANE_SRC]))
    else $error("assert_offer_win_R3");

  assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_MFRR)) |=> (mfrr_q == $past(op_data[PRIO_W-1:0])))
    else $error("assert_mfrr_store_R4");

  assert property (@(posedge clk) disable iff (rst)
    (xisr_q == '0) |-> (pprio_q == '1))
    else $error("assert_idle_prio_R5");

  assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_ACCEPT) && !src_valid)
      |=> (!irq_out && (cppr_q == $past(pprio_q))))
    else $error("assert_accept_R7");

  assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_EOI)) |=> (eoi_valid && (eoi_num == $past(op_data[NUM_W-1:0]))))
    else $error("assert_eoi_R8");

  assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_POLL) && !src_valid)
      |=> (rsp_valid && $stable(xisr_q) && $stable(cppr_q) && $stable(mfrr_q)))
    else $error("assert_poll_R9");
endmodule

// File: tb/sim_irq_presenter.sv
`timescale 1ns/1ps
module sim_irq_presenter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src_valid = 1'b0;
  logic [23:0] src_num = '0;
  logic [7:0]  src_prio = '0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic        irq_out;
  logic [1:0]  rej_valid;
  logic [47:0] rej_num;
  logic        eoi_valid;
  logic [23:0] eoi_num;
  logic        resend_req;
  logic        rsp_valid;
  logic [31:0] rsp_xirr;
  logic [7:0]  rsp_mfrr;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [2:0] C_CPPR = 3'd1, C_MFRR = 3'd2, C_ACC = 3'd3, C_EOI = 3'd4, C_POLL = 3'd5;

  always #2 clk = ~clk;

  irq_presenter u0 (
    .clk(clk), .rst(rst),
    .src_valid(src_valid), .src_num(src_num), .src_prio(src_prio),
    .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .irq_out(irq_out), .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req),
    .rsp_valid(rsp_valid), .rsp_xirr(rsp_xirr), .rsp_mfrr(rsp_mfrr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; outputs reflect it on return.
  task automatic step(input logic ov, input logic [2:0] oc, input logic [31:0] od,
                      input logic sv, input logic [23:0] sn, input logic [7:0] sp);
    @(negedge clk);
    op_valid = ov; op_code = oc; op_data = od;
    src_valid = sv; src_num = sn; src_prio = sp;
    @(negedge clk);
    op_valid = 1'b0; src_valid = 1'b0;
  endtask

  task automatic do_op(input logic [2:0] oc, input logic [31:0] od);
    step(1'b1, oc, od, 1'b0, '0, '0);
  endtask

  task automatic offer(input logic [23:0] sn, input logic [7:0] sp);
    step(1'b0, 3'd0, '0, 1'b1, sn, sp);
  endtask

  task automatic poll_chk(input string tag, input logic [31:0] xirr, input logic [7:0] mfrr);
    do_op(C_POLL, '0);
    chk({tag, " R9 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " R12 xirr"}, rsp_xirr, xirr);
    chk({tag, " mfrr"}, {24'd0, rsp_mfrr}, {24'd0, mfrr});
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    chk("R1 no reject after reset", {30'd0, rej_valid}, 32'd0);
    poll_chk("R1 reset state", 32'h0000_0000, 8'hFF);
  endtask

  task automatic t_offers;
    offer(24'h40, 8'h05);
    chk("R2 lose to cppr 0 lanes", {30'd0, rej_valid}, 32'd2);
    chk("R2 lose num", {8'd0, rej_num[47:24]}, 32'h40);
    chk("R2 line stays low", {31'd0, irq_out}, 32'd0);
    do_op(C_CPPR, 32'hFF);
    chk("R6 resend on looser cppr", {31'd0, resend_req}, 32'd1);
    chk("R6 no ipi when mfrr not below", {31'd0, irq_out}, 32'd0);
    offer(24'h40, 8'h05);
    chk("R3 win raises line", {31'd0, irq_out}, 32'd1);
    chk("R3 win no reject", {30'd0, rej_valid}, 32'd0);
    poll_chk("R3 latched", 32'hFF00_0040, 8'hFF);
    offer(24'h41, 8'h05);
    chk("R2 equal prio lanes", {30'd0, rej_valid}, 32'd2);
    chk("R2 equal prio num", {8'd0, rej_num[47:24]}, 32'h41);
    offer(24'h42, 8'h03);
    chk("R3 displace lanes", {30'd0, rej_valid}, 32'd2);
    chk("R3 displaced num", {8'd0, rej_num[47:24]}, 32'h40);
    poll_chk("R3 new pending", 32'hFF00_0042, 8'hFF);
  endtask

  task automatic t_cppr_ipi;
    do_op(C_CPPR, 32'h03);
    chk("R5 eject lanes", {30'd0, rej_valid}, 32'd1);
    chk("R5 eject num", {8'd0, rej_num[23:0]}, 32'h42);
    chk("R5 line low", {31'd0, irq_out}, 32'd0);
    poll_chk("R5 cleared", 32'h0300_0000, 8'hFF);
    do_op(C_MFRR, 32'h01);
    chk("R4 ipi raises line", {31'd0, irq_out}, 32'd1);
    chk("R4 ipi no reject", {30'd0, rej_valid}, 32'd0);
    poll_chk("R4 ipi pending", 32'h0300_0002, 8'h01);
  endtask

  task automatic t_accept_eoi;
    do_op(C_ACC, '0);
    chk("R7 accept rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R7 accept returns old word", rsp_xirr, 32'h0300_0002);
    chk("R7 accept lowers line", {31'd0, irq_out}, 32'd0);
    poll_chk("R7 after accept", 32'h0100_0000, 8'h01);
    do_op(C_EOI, 32'h0300_0002);
    chk("R8 eoi strobe", {31'd0, eoi_valid}, 32'd1);
    chk("R8 eoi num", {8'd0, eoi_num}, 32'h2);
    chk("R8 resend", {31'd0, resend_req}, 32'd1);
    chk("R8 ipi re-raised", {31'd0, irq_out}, 32'd1);
    poll_chk("R8 after eoi", 32'h0300_0002, 8'h01);
    do_op(C_MFRR, 32'hFF);
    chk("R4 no check when not below", {31'd0, irq_out}, 32'd1);
    poll_chk("R4 stored ff", 32'h0300_0002, 8'hFF);
    do_op(C_ACC, '0);
    chk("R7 second accept", rsp_xirr, 32'h0300_0002);
    do_op(C_EOI, 32'hFF00_0002);
    chk("R8 resend idle", {31'd0, resend_req}, 32'd1);
    chk("R8 no ipi", {31'd0, irq_out}, 32'd0);
    poll_chk("R8 idle", 32'hFF00_0000, 8'hFF);
  endtask

  task automatic t_same_cycle;
    step(1'b1, C_MFRR, 32'h10, 1'b1, 24'h50, 8'h08);
    chk("R11 ipi displaced silently", {30'd0, rej_valid}, 32'd0);
    chk("R10 line high", {31'd0, irq_out}, 32'd1);
    poll_chk("R10 offer beat ipi", 32'hFF00_0050, 8'h10);
    step(1'b1, C_CPPR, 32'h05, 1'b1, 24'h60, 8'h02);
    chk("R10 op lane only", {30'd0, rej_valid}, 32'd1);
    chk("R10 op lane num", {8'd0, rej_num[23:0]}, 32'h50);
    chk("R10 line high", {31'd0, irq_out}, 32'd1);
    poll_chk("R10 offer after eject", 32'h0500_0060, 8'h10);
    step(1'b1, C_CPPR, 32'h01, 1'b1, 24'h70, 8'h01);
    chk("R10 both lanes", {30'd0, rej_valid}, 32'd3);
    chk("R10 lane0 num", {8'd0, rej_num[23:0]}, 32'h60);
    chk("R10 lane1 num", {8'd0, rej_num[47:24]}, 32'h70);
    chk("R10 line low", {31'd0, irq_out}, 32'd0);
    poll_chk("R10 both gone", 32'h0100_0000, 8'h10);
  endtask

  task automatic t_ipi_hold;
    do_op(C_CPPR, 32'hFF);
    chk("R6 resend", {31'd0, resend_req}, 32'd1);
    chk("R6 ipi from resend", {31'd0, irq_out}, 32'd1);
    poll_chk("R6 ipi pending", 32'hFF00_0002, 8'h10);
    offer(24'h80, 8'h04);
    chk("R11 no reject of ipi", {30'd0, rej_valid}, 32'd0);
    do_op(C_MFRR, 32'h04);
    chk("R4 equal pending holds", {30'd0, rej_valid}, 32'd0);
    poll_chk("R4 held", 32'hFF00_0080, 8'h04);
    do_op(C_MFRR, 32'h03);
    chk("R4 ipi ejects lanes", {30'd0, rej_valid}, 32'd1);
    chk("R4 ipi ejects num", {8'd0, rej_num[23:0]}, 32'h80);
    poll_chk("R4 ipi took over", 32'hFF00_0002, 8'h03);
    do_op(C_EOI, 32'hFF00_0080);
    chk("R8 no resend while pending", {31'd0, resend_req}, 32'd0);
    chk("R8 line stays", {31'd0, irq_out}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_offers;
    t_cppr_ipi;
    t_accept_eoi;
    t_same_cycle;
    t_ipi_hold;
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule